// File: doc/BRIEF.md
# Zero-Gated Row-Stationary Processing Element

This block is one processing element of a convolution array that works row by row. After a configuration handshake it takes one row of S filter weights into a small local store. It then takes S input activations into a window store and produces one output partial sum per window position. Between outputs the window slides by the stride U: the oldest U activations drop out and U new ones come in. Each output is the signed dot product of the weight row with the current window. The multiply-accumulate path is a three-stage pipeline: scratch-pad access first, then multiply, then accumulate.

Every activation slot has a one-bit zero flag, set when a zero is written into that slot. A slot flagged as zero still takes a pipeline step. However, the weight store is not read for it, and the operand and product registers keep their values. The number of cycles to an output does not depend on how many activations are zero, but the datapath does not switch for those slots. In chained mode the element also takes one incoming partial sum from its neighbour in the same column for each output and adds it before sending the result on. It raises a done flag after it sends the last output of the row.

Top module: `zg_rs_pe`

## Requirements
- R1: While reset is held and after it is released, cfg_ready is 1 and done, wgt_ready, act_ready, psi_ready and pso_valid are all 0.
- R2: A configuration (cfg_len = S in 1..12, cfg_stride = U in 1..S, cfg_count = N in 1..64, cfg_chain) is taken only while cfg_ready is 1. cfg_ready is 0 from the accepting edge until the run ends, and values offered on the config port during a run do not change its outputs.
- R3: After a configuration is accepted, exactly S weights are taken on the weight port. The first weight taken is position 0.
- R4: Output k (k = 0..N-1) is the sum over j = 0..S-1 of weight[j] times activation[k*U + j], where activation index 0 is the first one taken. The arithmetic is signed two's complement and the result is 2*8+4 = 20 bits wide, modulo 2^20.
- R5: A run takes exactly S + U*(N-1) activations: S before the first output, then U after each output except the last.
- R6: A zero activation contributes nothing to the sum. While it passes, the registered weight operand and the product register keep their values.
- R7: With cfg_chain = 1, exactly one partial sum is taken on psi for each output, after that output's multiply-accumulate, and it is added into the output. With cfg_chain = 0, psi_ready stays 0.
- R8: Once pso_valid is 1, it stays 1 and pso_data stays the same until pso_ready is 1.
- R9: done rises on the edge that sends the Nth output, stays 1 while the element is idle, and clears when the next configuration is accepted. At most one of cfg_ready, wgt_ready, act_ready, psi_ready and pso_valid is 1 in any cycle.
- R10: With cfg_chain = 0, pso_valid rises on the (S+3)th clock edge after the edge that accepts the last activation of a window, whatever number of them are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_valid | input | 1 | Configuration offered |
| cfg_ready | output | 1 | Element idle, configuration can be taken |
| cfg_len | input | 4 | Filter row length S |
| cfg_stride | input | 4 | Window stride U |
| cfg_count | input | 7 | Number of outputs N in the row |
| cfg_chain | input | 1 | 1: add a neighbour partial sum into every output |
| wgt_valid | input | 1 | Weight offered |
| wgt_ready | output | 1 | Weight can be taken |
| wgt_data | input | 8 | Signed weight |
| act_valid | input | 1 | Activation offered |
| act_ready | output | 1 | Activation can be taken |
| act_data | input | 8 | Signed activation |
| psi_valid | input | 1 | Neighbour partial sum offered |
| psi_ready | output | 1 | Neighbour partial sum can be taken |
| psi_data | input | 20 | Signed neighbour partial sum |
| pso_valid | output | 1 | Output partial sum available |
| pso_ready | input | 1 | Downstream takes the output |
| pso_data | output | 20 | Signed output partial sum |
| done | output | 1 | Last output of the row has been sent |

## Verification
The assertions run on every cycle. They check zero gating inside the datapath: the weight operand register stays fixed when a flagged slot is issued, and the product register stays fixed when a flagged slot reaches the multiplier. They also check that only one port is active at a time, that the output is held under backpressure, that a chain add leads straight into a send, and that done occurs only while the element is idle. Only the bench scenarios show the arithmetic across window slides, strides, extreme operands and all-zero windows. The same applies to the exact input counts per run, the fixed latency with zeros present, the chain addition, and the fact that config values offered during a run are ignored.

// File: rtl/zgpe_pkg.sv
// Shared definitions for the zero-gated row-stationary processing element.
// Assumes nothing beyond the parameters of the modules that import it.
package zgpe_pkg;

    // Phases of one row run, in the order a run visits them.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_LOADW = 3'd1,
        PH_FILL  = 3'd2,
        PH_MAC   = 3'd3,
        PH_DRAIN = 3'd4,
        PH_PSUM  = 3'd5,
        PH_SEND  = 3'd6,
        PH_SLIDE = 3'd7
    } pe_phase_t;

endpackage

// File: rtl/zgpe_wgt_spad.sv
// Filter-row scratch pad: DEPTH signed weights, written one at a time by
// index, read through a registered port. When rd_en is low the output
// register keeps its value, so a skipped read leaves the operand frozen.
// Assumes write and read never target the same entry in the same cycle.
module zgpe_wgt_spad #(
    parameter int DW    = 8,
    parameter int DEPTH = 12,
    parameter int IW    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IW-1:0]        wr_idx,
    input  logic signed [DW-1:0] wr_data,
    input  logic                 rd_en,
    input  logic [IW-1:0]        rd_idx,
    output logic signed [DW-1:0] rd_q
);

    logic signed [DW-1:0] mem [DEPTH];

    // Store an incoming weight at its position in the row.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Registered read, held when the read is gated off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= mem[rd_idx];
        end
    end

endmodule

// File: rtl/zgpe_act_window.sv
// Activation window scratch pad with a one-bit zero flag per slot.
// Every shift moves all slots one place toward slot 0. The new value
// enters at slot len-1, so after len shifts slot 0 holds the oldest value.
// Slots above len-1 hold stale data that is never read.
// Assumes 1 <= len <= DEPTH and rd_idx < len.
module zgpe_act_window #(
    parameter int DW    = 8,
    parameter int DEPTH = 12,
    parameter int IW    = 4,
    parameter int LW    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic [LW-1:0]        len,
    input  logic signed [DW-1:0] din,
    input  logic [IW-1:0]        rd_idx,
    output logic signed [DW-1:0] rd_data,
    output logic                 rd_zero
);

    logic signed [DW-1:0] win   [DEPTH];
    logic [DEPTH-1:0]     zflag;

    generate
        for (genvar j = 0; j < DEPTH; j++) begin : g_slot
            logic signed [DW-1:0] up_val;
            logic                 up_zero;

            // Value arriving from the slot above (the last slot keeps its own).
            if (j < DEPTH - 1) begin : g_mid
                assign up_val  = win[j+1];
                assign up_zero = zflag[j+1];
            end else begin : g_top
                assign up_val  = win[j];
                assign up_zero = zflag[j];
            end

            // Shift the slot and its zero flag together; the entry slot takes the new value.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    win[j]   <= '0;
                    zflag[j] <= 1'b0;
                end else if (shift_en) begin
                    if (LW'(j) == len - LW'(1)) begin
                        win[j]   <= din;
                        zflag[j] <= (din == '0);
                    end else begin
                        win[j]   <= up_val;
                        zflag[j] <= up_zero;
                    end
                end
            end
        end
    endgenerate

    // Combinational read of the slot under issue and its zero flag.
    always_comb begin
        rd_data = win[rd_idx];
        rd_zero = zflag[rd_idx];
    end

endmodule

// File: rtl/zgpe_mac_pipe.sv
// Three-stage multiply-accumulate. Stage 1 registers the activation
// operand (the weight operand is registered in the weight scratch pad in
// the same cycle). Stage 2 multiplies. Stage 3 accumulates. A zero-flagged
// step moves through the valid bits but loads no operand, product or sum.
// Also adds an incoming partial sum into the accumulator on request.
// Assumes acc_clr, psi_add and a stage-3 add never fall in the same cycle.
module zgpe_mac_pipe #(
    parameter int DW = 8,
    parameter int AW = 20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   issue,
    input  logic                   op_zero,
    input  logic signed [DW-1:0]   op_act,
    input  logic signed [DW-1:0]   op_wgt,
    input  logic                   acc_clr,
    input  logic                   psi_add,
    input  logic signed [AW-1:0]   psi_val,
    output logic                   busy,
    output logic                   s1_zero,
    output logic signed [2*DW-1:0] prod_q,
    output logic signed [AW-1:0]   acc_q
);

    localparam int PW = 2 * DW;

    logic                 s1_v;
    logic                 s2_v;
    logic                 s2_z;
    logic signed [DW-1:0] act_q;

    // Stage 1: take the activation operand unless the slot is flagged zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v    <= 1'b0;
            s1_zero <= 1'b0;
            act_q   <= '0;
        end else begin
            s1_v    <= issue;
            s1_zero <= issue && op_zero;
            if (issue && !op_zero) begin
                act_q <= op_act;
            end
        end
    end

    // Stage 2: multiply live operands; a gated step leaves the product untouched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_v   <= 1'b0;
            s2_z   <= 1'b0;
            prod_q <= '0;
        end else begin
            s2_v <= s1_v;
            s2_z <= s1_zero;
            if (s1_v && !s1_zero) begin
                prod_q <= act_q * op_wgt;
            end
        end
    end

    // Stage 3: clear, add the neighbour sum, or accumulate a live product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (acc_clr) begin
            acc_q <= '0;
        end else if (psi_add) begin
            acc_q <= acc_q + psi_val;
        end else if (s2_v && !s2_z) begin
            acc_q <= acc_q + {{(AW-PW){prod_q[PW-1]}}, prod_q};
        end
    end

    // Steps still in flight before the accumulator is final.
    always_comb begin
        busy = s1_v || s2_v;
    end

endmodule

// File: rtl/zgpe_ctrl.sv
// Run controller: takes the configuration, sequences weight load, window
// fill, S issue steps, pipeline drain, the optional neighbour add, the
// send, and the stride slide, and counts the outputs of the row.
// Assumes the configuration is legal: 1 <= S <= depth, 1 <= U <= S, N >= 1.
module zgpe_ctrl
    import zgpe_pkg::*;
#(
    parameter int LW = 4,
    parameter int NW = 7,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_valid,
    input  logic [LW-1:0] cfg_len,
    input  logic [LW-1:0] cfg_stride,
    input  logic [NW-1:0] cfg_count,
    input  logic          cfg_chain,
    input  logic          wgt_valid,
    input  logic          act_valid,
    input  logic          psi_valid,
    input  logic          pso_ready,
    input  logic          pipe_busy,
    output logic          cfg_ready,
    output logic          wgt_ready,
    output logic          act_ready,
    output logic          psi_ready,
    output logic          pso_valid,
    output logic          done,
    output logic [LW-1:0] len_q,
    output logic [IW-1:0] step_idx,
    output logic          w_wr_en,
    output logic          act_shift,
    output logic          issue,
    output logic          acc_clr,
    output logic          psi_add
);

    pe_phase_t     phase;
    logic [LW-1:0] cnt;
    logic [LW-1:0] stride_q;
    logic [NW-1:0] left_q;
    logic          chain_q;
    logic          done_q;
    logic          last_len;
    logic          last_stride;

    // Port strobes and datapath controls decoded from the phase.
    always_comb begin
        cfg_ready   = (phase == PH_IDLE);
        wgt_ready   = (phase == PH_LOADW);
        act_ready   = (phase == PH_FILL) || (phase == PH_SLIDE);
        psi_ready   = (phase == PH_PSUM);
        pso_valid   = (phase == PH_SEND);
        issue       = (phase == PH_MAC);
        done        = done_q;
        step_idx    = IW'(cnt);
        last_len    = (cnt == len_q - LW'(1));
        last_stride = (cnt == stride_q - LW'(1));
        acc_clr     = issue && (cnt == '0);
        w_wr_en     = wgt_ready && wgt_valid;
        act_shift   = act_ready && act_valid;
        psi_add     = psi_ready && psi_valid;
    end

    // Phase, step counter, output counter and done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            len_q    <= '0;
            stride_q <= '0;
            left_q   <= '0;
            chain_q  <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (cfg_valid) begin
                        len_q    <= cfg_len;
                        stride_q <= cfg_stride;
                        left_q   <= cfg_count;
                        chain_q  <= cfg_chain;
                        done_q   <= 1'b0;
                        cnt      <= '0;
                        phase    <= PH_LOADW;
                    end
                end
                PH_LOADW: begin
                    if (wgt_valid) begin
                        if (last_len) begin
                            cnt   <= '0;
                            phase <= PH_FILL;
                        end else begin
                            cnt <= cnt + LW'(1);
                        end
                    end
                end
                PH_FILL: begin
                    if (act_valid) begin
                        if (last_len) begin
                            cnt   <= '0;
                            phase <= PH_MAC;
                        end else begin
                            cnt <= cnt + LW'(1);
                        end
                    end
                end
                PH_MAC: begin
                    if (last_len) begin
                        cnt   <= '0;
                        phase <= PH_DRAIN;
                    end else begin
                        cnt <= cnt + LW'(1);
                    end
                end
                PH_DRAIN: begin
                    if (!pipe_busy) begin
                        phase <= chain_q ? PH_PSUM : PH_SEND;
                    end
                end
                PH_PSUM: begin
                    if (psi_valid) begin
                        phase <= PH_SEND;
                    end
                end
                PH_SEND: begin
                    if (pso_ready) begin
                        if (left_q == NW'(1)) begin
                            done_q <= 1'b1;
                            phase  <= PH_IDLE;
                        end else begin
                            left_q <= left_q - NW'(1);
                            cnt    <= '0;
                            phase  <= PH_SLIDE;
                        end
                    end
                end
                PH_SLIDE: begin
                    if (act_valid) begin
                        if (last_stride) begin
                            cnt   <= '0;
                            phase <= PH_MAC;
                        end else begin
                            cnt <= cnt + LW'(1);
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/zg_rs_pe.sv
// Zero-gated row-stationary processing element. It ties together the
// controller, the weight scratch pad, the activation window with its zero
// flags, and the three-stage MAC pipe. The weight read is enabled only for
// an issued slot whose zero flag is clear.
// Assumes a legal configuration, as the controller does.
module zg_rs_pe #(
    parameter int DW      = 8,
    parameter int MAX_S   = 12,
    parameter int MAX_OUT = 64,
    parameter int LW      = $clog2(MAX_S + 1),
    parameter int NW      = $clog2(MAX_OUT + 1),
    parameter int AW      = 2 * DW + $clog2(MAX_S)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_valid,
    output logic          cfg_ready,
    input  logic [LW-1:0] cfg_len,
    input  logic [LW-1:0] cfg_stride,
    input  logic [NW-1:0] cfg_count,
    input  logic          cfg_chain,
    input  logic          wgt_valid,
    output logic          wgt_ready,
    input  logic [DW-1:0] wgt_data,
    input  logic          act_valid,
    output logic          act_ready,
    input  logic [DW-1:0] act_data,
    input  logic          psi_valid,
    output logic          psi_ready,
    input  logic [AW-1:0] psi_data,
    output logic          pso_valid,
    input  logic          pso_ready,
    output logic [AW-1:0] pso_data,
    output logic          done
);

    localparam int IW = $clog2(MAX_S);

    logic [LW-1:0]        len_q;
    logic [IW-1:0]        step_idx;
    logic                 w_wr_en;
    logic                 act_shift;
    logic                 issue;
    logic                 acc_clr;
    logic                 psi_add;
    logic                 pipe_busy;
    logic                 cur_zero;
    logic                 w_rd_en;
    logic                 s1_zero;
    logic signed [DW-1:0] cur_act;
    logic signed [DW-1:0] wgt_rdq;
    logic signed [2*DW-1:0] prod_q;
    logic signed [AW-1:0] acc_q;

    zgpe_ctrl #(.LW(LW), .NW(NW), .IW(IW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_valid  (cfg_valid),
        .cfg_len    (cfg_len),
        .cfg_stride (cfg_stride),
        .cfg_count  (cfg_count),
        .cfg_chain  (cfg_chain),
        .wgt_valid  (wgt_valid),
        .act_valid  (act_valid),
        .psi_valid  (psi_valid),
        .pso_ready  (pso_ready),
        .pipe_busy  (pipe_busy),
        .cfg_ready  (cfg_ready),
        .wgt_ready  (wgt_ready),
        .act_ready  (act_ready),
        .psi_ready  (psi_ready),
        .pso_valid  (pso_valid),
        .done       (done),
        .len_q      (len_q),
        .step_idx   (step_idx),
        .w_wr_en    (w_wr_en),
        .act_shift  (act_shift),
        .issue      (issue),
        .acc_clr    (acc_clr),
        .psi_add    (psi_add)
    );

    // Weight read only for an issued slot holding a non-zero activation.
    always_comb begin
        w_rd_en = issue && !cur_zero;
    end

    zgpe_wgt_spad #(.DW(DW), .DEPTH(MAX_S), .IW(IW)) u_wgt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (w_wr_en),
        .wr_idx  (step_idx),
        .wr_data (wgt_data),
        .rd_en   (w_rd_en),
        .rd_idx  (step_idx),
        .rd_q    (wgt_rdq)
    );

    zgpe_act_window #(.DW(DW), .DEPTH(MAX_S), .IW(IW), .LW(LW)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (act_shift),
        .len      (len_q),
        .din      (act_data),
        .rd_idx   (step_idx),
        .rd_data  (cur_act),
        .rd_zero  (cur_zero)
    );

    zgpe_mac_pipe #(.DW(DW), .AW(AW)) u_mac (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue   (issue),
        .op_zero (cur_zero),
        .op_act  (cur_act),
        .op_wgt  (wgt_rdq),
        .acc_clr (acc_clr),
        .psi_add (psi_add),
        .psi_val (psi_data),
        .busy    (pipe_busy),
        .s1_zero (s1_zero),
        .prod_q  (prod_q),
        .acc_q   (acc_q)
    );

    // The accumulator is the output register.
    always_comb begin
        pso_data = acc_q;
    end

endmodule

// File: rtl/zg_rs_pe_chk.sv
// Property checker for zg_rs_pe, attached to every instance by bind.
// Watches port handshakes and the gated datapath registers.
module zg_rs_pe_chk #(
    parameter int DW    = 8,
    parameter int MAX_S = 12,
    parameter int AW    = 2 * DW + $clog2(MAX_S)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_ready,
    input logic            wgt_ready,
    input logic            act_ready,
    input logic            psi_ready,
    input logic            psi_valid,
    input logic            pso_valid,
    input logic            pso_ready,
    input logic [AW-1:0]   pso_data,
    input logic            done,
    input logic            issue,
    input logic            cur_zero,
    input logic            s1_zero,
    input logic [DW-1:0]   wgt_rdq,
    input logic [2*DW-1:0] prod_q
);

    // R6
    wgt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue && cur_zero |=> $stable(wgt_rdq));

    // R6
    prod_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_zero |=> $stable(prod_q));

    // R8
    pso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pso_valid && !pso_ready |=> pso_valid && $stable(pso_data));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ready |-> !(wgt_ready || act_ready || psi_ready || pso_valid));

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cfg_ready);

    // R9
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_ready, wgt_ready, act_ready, psi_ready, pso_valid}));

    // R7
    psi_then_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psi_ready && psi_valid |=> pso_valid);

endmodule

bind zg_rs_pe zg_rs_pe_chk #(.DW(DW), .MAX_S(MAX_S)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_ready (cfg_ready),
    .wgt_ready (wgt_ready),
    .act_ready (act_ready),
    .psi_ready (psi_ready),
    .psi_valid (psi_valid),
    .pso_valid (pso_valid),
    .pso_ready (pso_ready),
    .pso_data  (pso_data),
    .done      (done),
    .issue     (issue),
    .cur_zero  (cur_zero),
    .s1_zero   (s1_zero),
    .wgt_rdq   (wgt_rdq),
    .prod_q    (prod_q)
);

// File: tb/sim_zg_rs_pe.sv
// Bench for zg_rs_pe: a behavioural dot-product model with stream
// sources and a negedge monitor that compares the ports every clock.
module sim_zg_rs_pe;

    localparam int DW = 8;
    localparam int MAX_S = 12;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_valid = 1'b0;
    logic          cfg_ready;
    logic [3:0]    cfg_len = '0;
    logic [3:0]    cfg_stride = '0;
    logic [6:0]    cfg_count = '0;
    logic          cfg_chain = 1'b0;
    logic          wgt_valid = 1'b0;
    logic          wgt_ready;
    logic [DW-1:0] wgt_data = '0;
    logic          act_valid = 1'b0;
    logic          act_ready;
    logic [DW-1:0] act_data = '0;
    logic          psi_valid = 1'b0;
    logic          psi_ready;
    logic [AW-1:0] psi_data = '0;
    logic          pso_valid;
    logic          pso_ready = 1'b0;
    logic [AW-1:0] pso_data;
    logic          done;

    zg_rs_pe u0 (.*);

    always #2ns clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    // Run description shared by tasks, sources and monitor.
    int w_arr [16];
    int a_arr [256];
    int p_arr [64];
    logic [AW-1:0] e_arr [64];
    int cur_s = 1, cur_u = 1, cur_n = 1, cur_a = 0;
    bit cur_chain = 0, bubbles = 0, backp = 0, run_on = 0;
    string val_tag = "R4";
    // Handshake counts, written only by the monitor.
    int wgt_hs = 0, act_hs = 0, psi_hs = 0, out_hs = 0;
    int cyc_n = 0, win_cyc = 0;
    bit pso_prev = 0, pso_stall = 0;
    logic [AW-1:0] pso_last = '0;
    int seed = 7;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int rnd8();
        seed = seed * 1103515245 + 12345;
        return int'($signed(seed[23:16]));
    endfunction

    // Sources: present the next item, with optional bubbles.
    int pcyc = 0;
    always @(posedge clk) begin
        #1ns;
        pcyc++;
        wgt_valid = run_on && (wgt_hs < cur_s) && !(bubbles && pcyc % 3 == 1);
        wgt_data  = DW'(w_arr[wgt_hs % 16]);
        act_valid = run_on && (act_hs < cur_a) && !(bubbles && pcyc % 3 == 2);
        act_data  = DW'(a_arr[act_hs % 256]);
        psi_valid = run_on && cur_chain && (psi_hs < cur_n) && !(bubbles && pcyc % 3 == 0);
        psi_data  = AW'(p_arr[psi_hs % 64]);
        pso_ready = backp ? (pcyc % 4 >= 2) : 1'b1;
    end

    // Monitor: compares every clock against the model, away from the edge.
    always @(negedge clk) begin
        cyc_n++;
        if (rst_n) begin
            if (cfg_valid && cfg_ready) begin
                wgt_hs = 0; act_hs = 0; psi_hs = 0; out_hs = 0;
            end else begin
                if (wgt_ready && wgt_hs >= cur_s)
                    chk(0, "R3 extra weight requested", wgt_hs, cur_s);
                if (act_ready && act_hs >= cur_a)
                    chk(0, "R5 extra activation requested", act_hs, cur_a);
                if (psi_ready && !cur_chain)
                    chk(0, "R7 psi_ready without chain", 1, 0);
                if (pso_stall)
                    chk(pso_valid && pso_data == pso_last, "R8 held output", pso_data, pso_last);
                if (pso_valid && !pso_prev && !cur_chain)
                    chk(cyc_n - win_cyc == cur_s + 4, "R10 latency", cyc_n - win_cyc, cur_s + 4);
                if (wgt_valid && wgt_ready) wgt_hs++;
                if (act_valid && act_ready) begin
                    act_hs++;
                    if (act_hs == cur_s || (act_hs > cur_s && (act_hs - cur_s) % cur_u == 0))
                        win_cyc = cyc_n;
                end
                if (psi_valid && psi_ready) psi_hs++;
                if (pso_valid && pso_ready) begin
                    if (out_hs < cur_n)
                        chk(pso_data == e_arr[out_hs], val_tag, $signed(pso_data), $signed(e_arr[out_hs]));
                    else
                        chk(0, "R5 extra output", out_hs, cur_n);
                    out_hs++;
                end
            end
        end
        pso_stall = pso_valid && !pso_ready;
        pso_last  = pso_data;
        pso_prev  = pso_valid;
    end

    // zmode: 0 random, 1 about a third zero, 2 all zero, 3 all -128.
    task automatic run(input int s, input int u, input int n, input bit chain,
                       input int zmode, input bit bub, input bit bp, input bit junk,
                       input string tag);
        int na;
        na = s + u * (n - 1);
        for (int j = 0; j < s; j++) w_arr[j] = (zmode == 3) ? -128 : rnd8();
        for (int i = 0; i < na; i++) begin
            case (zmode)
                1: a_arr[i] = (rnd8() % 3 == 0) ? 0 : rnd8();
                2: a_arr[i] = 0;
                3: a_arr[i] = -128;
                default: a_arr[i] = rnd8();
            endcase
        end
        for (int k = 0; k < n; k++) begin
            longint sum = 0;
            p_arr[k] = rnd8() * 13;
            for (int j = 0; j < s; j++) sum += longint'(w_arr[j]) * longint'(a_arr[k * u + j]);
            if (chain) sum += p_arr[k];
            e_arr[k] = AW'(sum);
        end
        @(posedge clk); #1ns;
        cur_s = s; cur_u = u; cur_n = n; cur_a = na; cur_chain = chain;
        bubbles = bub; backp = bp; val_tag = tag;
        cfg_len = 4'(s); cfg_stride = 4'(u); cfg_count = 7'(n); cfg_chain = chain;
        cfg_valid = 1'b1;
        do @(negedge clk); while (!cfg_ready);
        @(posedge clk); #1ns;
        cfg_valid = 1'b0;
        run_on = 1;
        @(negedge clk);
        chk(done == 1'b0, "R9 done clears on config", done, 0);
        chk(cfg_ready == 1'b0, "R2 busy after config", cfg_ready, 0);
        if (junk) begin
            @(posedge clk); #1ns;
            cfg_len = 4'd2; cfg_stride = 4'd1; cfg_count = 7'd1; cfg_chain = !chain;
            cfg_valid = 1'b1;
            while (out_hs < 1) @(negedge clk);
            @(posedge clk); #1ns;
            cfg_valid = 1'b0;
        end
        while (out_hs < n) @(negedge clk);
        @(negedge clk);
        chk(done == 1'b1, "R9 done after last output", done, 1);
        chk(cfg_ready == 1'b1, "R9 idle after last output", cfg_ready, 1);
        chk(wgt_hs == s, "R3 weights taken", wgt_hs, s);
        chk(act_hs == na, "R5 activations taken", act_hs, na);
        chk(psi_hs == (chain ? n : 0), "R7 partial sums taken", psi_hs, chain ? n : 0);
        run_on = 0;
        repeat (3) @(negedge clk);
        chk(done == 1'b1, "R9 done holds while idle", done, 1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(cfg_ready == 1'b1 && done == 1'b0, "R1 reset idle", {cfg_ready, done}, 2);
        @(posedge clk); #1ns;
        rst_n = 1'b1;
        @(negedge clk);
        // R1 after release
        chk(!wgt_ready && !act_ready && !psi_ready && !pso_valid && cfg_ready && !done,
            "R1 after reset", {wgt_ready, act_ready, psi_ready, pso_valid, cfg_ready, done}, 2);
        run(3, 1, 6, 0, 0, 0, 0, 0, "R4 stride1");
        run(5, 2, 4, 0, 0, 1, 0, 0, "R5 stride2");
        run(5, 2, 4, 1, 1, 0, 0, 1, "R2 R6 R7 zeros chain junk cfg");
        run(7, 3, 3, 0, 1, 0, 1, 0, "R6 R8 zeros backpressure");
        run(12, 3, 2, 1, 2, 1, 0, 0, "R6 all zero window");
        run(12, 12, 2, 0, 3, 0, 0, 0, "R4 extreme operands");
        run(1, 1, 3, 1, 0, 1, 1, 0, "R7 single tap chain");
        run(4, 4, 3, 0, 1, 0, 0, 1, "R2 R10 junk cfg stride eq len");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule